// File: doc/BRIEF.md
# Paged Address Translator

This block maps 16-bit virtual addresses onto 16-bit physical addresses. Pages are 1 KB and the page table has 64 entries, all held inside the block. The upper six address bits select a table entry. If that entry is valid and its page number lies below the programmable table length, the frame number stored in the entry takes the place of the page number. The ten offset bits pass through unchanged, and no adder is involved.

A lookup also records usage in the entry. Any successful access marks the page as referenced, and a successful write also marks it as modified. A request that fails the length check or hits an invalid entry returns a fault with the page number that caused it and leaves the table unchanged. A configuration port writes whole entries, reads them back and sets the table length. The block takes one request per cycle and returns one registered response per cycle.

Top module: `page_xlate_top`

## Requirements
- R1: The low 10 bits of a non-faulting response address equal the low 10 bits of the request address.
- R2: The upper 6 bits of a non-faulting response address equal the frame field of the entry indexed by request bits [15:10]. For example, VA 0x041C with entry 1 holding frame 7 gives PA 0x1C1C.
- R3: A request whose indexed entry has its valid bit clear returns a fault, and the response address is 0.
- R4: A request whose page number is greater than or equal to the table length returns a fault, even when the entry is valid. A page number of length-1 is legal. The length resets to 64 and is loaded from `len_i` when `len_we_i` is high.
- R5: A non-faulting request sets the entry's reference bit. A non-faulting write also sets its dirty bit. A read leaves the dirty bit unchanged.
- R6: A faulting request changes no bit of any entry.
- R7: Each request accepted at a clock edge produces exactly one response, with `rsp_valid_o` high, at that same edge. `rsp_vpn_o` carries the request's page number. No response appears in a cycle with no request.
- R8: After reset, every entry reads back as 0 (invalid) and `rsp_valid_o` is low.
- R9: Entry layout on the configuration port: bits [5:0] frame, bit 6 dirty, bit 7 reference, bit 8 valid. A write replaces the whole entry at the clock edge. `cfg_rdata_o` shows the entry selected by `cfg_idx_i` without delay.
- R10: A configuration write and a non-faulting translation to the same entry in the same cycle: the translation uses the old contents, and the configured value is what remains stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | 16 | Virtual address |
| req_write_i | input | 1 | Request is a store |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pa_o | output | 16 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Page fault |
| rsp_vpn_o | output | 6 | Page number of the request |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_idx_i | input | 6 | Entry index for write and readback |
| cfg_wdata_i | input | 9 | Entry value to write |
| cfg_rdata_o | output | 9 | Entry value at `cfg_idx_i` |
| len_we_i | input | 1 | Table length write strobe |
| len_i | input | 7 | New table length |

## Verification
The assertions assume that the request inputs are stable and known whenever `req_valid_i` is high at an edge. They also assume that the length register only changes through its strobe, so a bound fault can be predicted from the length held before the edge. The stimulus drives every input on the falling edge, so each value is settled a half period before it is sampled. Length writes and entry writes are mixed with requests, including writes to the entry being translated in the same cycle, and all of them come from the same falling-edge driver, so the assumptions hold throughout.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned PT_VA_W  = 16;
  localparam int unsigned PT_PA_W  = 16;
  localparam int unsigned PT_OFF_W = 10;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BOUND   = 2'd1,
    CAUSE_INVALID = 2'd2
  } fault_cause_e;
endpackage

// File: rtl/pt_store.sv
module pt_store #(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PFN_W = 6,
  localparam int unsigned N     = 1 << VPN_W,
  localparam int unsigned ENT_W = PFN_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic             upd_dirty_i,
  input  logic [VPN_W-1:0] upd_idx_i,
  input  logic             cfg_we_i,
  input  logic [VPN_W-1:0] cfg_idx_i,
  input  logic [ENT_W-1:0] cfg_wdata_i,
  input  logic [VPN_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o,
  output logic [ENT_W-1:0] cfg_rdata_o
);
  logic [N-1:0]       valid_q, ref_q, dirty_q;
  logic [PFN_W-1:0]   pfn_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic cfg_hit, upd_hit;
    assign cfg_hit = cfg_we_i && (cfg_idx_i == VPN_W'(g));
    assign upd_hit = upd_en_i && (upd_idx_i == VPN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        ref_q[g]   <= 1'b0;
        dirty_q[g] <= 1'b0;
        pfn_q[g]   <= '0;
      end else if (cfg_hit) begin
        // software write wins over status update
        pfn_q[g]   <= cfg_wdata_i[PFN_W-1:0];
        dirty_q[g] <= cfg_wdata_i[PFN_W];
        ref_q[g]   <= cfg_wdata_i[PFN_W+1];
        valid_q[g] <= cfg_wdata_i[PFN_W+2];
      end else if (upd_hit) begin
        ref_q[g] <= 1'b1;
        if (upd_dirty_i) dirty_q[g] <= 1'b1;
      end
    end
  end

  assign rd_ent_o    = {valid_q[rd_idx_i], ref_q[rd_idx_i], dirty_q[rd_idx_i], pfn_q[rd_idx_i]};
  assign cfg_rdata_o = {valid_q[cfg_idx_i], ref_q[cfg_idx_i], dirty_q[cfg_idx_i], pfn_q[cfg_idx_i]};
endmodule

// File: rtl/pt_lookup.sv
module pt_lookup
  import pt_pkg::*;
#(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PFN_W = 6,
  parameter int unsigned OFF_W = 10,
  localparam int unsigned ENT_W = PFN_W + 3,
  localparam int unsigned PA_W  = PFN_W + OFF_W
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [VPN_W:0]   len_i,
  input  logic [ENT_W-1:0] ent_i,
  output fault_cause_e     cause_o,
  output logic [PA_W-1:0]  pa_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    if ({1'b0, vpn_i} >= len_i)  cause_o = CAUSE_BOUND;
    else if (!ent_i[PFN_W+2])    cause_o = CAUSE_INVALID;
  end

  assign pa_o = (cause_o == CAUSE_NONE) ? {ent_i[PFN_W-1:0], off_i} : '0;
endmodule

// File: rtl/pt_rsp.sv
module pt_rsp #(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PA_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fault_i,
  input  logic [PA_W-1:0]  pa_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             valid_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [VPN_W-1:0] vpn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      pa_o    <= '0;
      vpn_o   <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        fault_o <= fault_i;
        pa_o    <= pa_i;
        vpn_o   <= vpn_i;
      end
    end
  end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
  import pt_pkg::*;
#(
  parameter int unsigned VA_W  = PT_VA_W,
  parameter int unsigned PA_W  = PT_PA_W,
  parameter int unsigned OFF_W = PT_OFF_W,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PFN_W = PA_W - OFF_W,
  localparam int unsigned ENT_W = PFN_W + 3,
  localparam int unsigned N     = 1 << VPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o,
  output logic [VPN_W-1:0] rsp_vpn_o,
  input  logic             cfg_we_i,
  input  logic [VPN_W-1:0] cfg_idx_i,
  input  logic [ENT_W-1:0] cfg_wdata_i,
  output logic [ENT_W-1:0] cfg_rdata_o,
  input  logic             len_we_i,
  input  logic [VPN_W:0]   len_i
);
  logic [VPN_W-1:0] vpn;
  logic [ENT_W-1:0] ent;
  logic [PA_W-1:0]  pa;
  logic [VPN_W:0]   len_q;
  fault_cause_e     cause;
  logic             hit;

  assign vpn = req_va_i[VA_W-1:OFF_W];
  assign hit = req_valid_i && (cause == CAUSE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= (VPN_W+1)'(N);
    else if (len_we_i) len_q <= len_i;
  end

  pt_store #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk_i, .rst_ni,
    .upd_en_i    (hit),
    .upd_dirty_i (req_write_i),
    .upd_idx_i   (vpn),
    .cfg_we_i, .cfg_idx_i, .cfg_wdata_i,
    .rd_idx_i    (vpn),
    .rd_ent_o    (ent),
    .cfg_rdata_o
  );

  pt_lookup #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_lookup (
    .vpn_i   (vpn),
    .off_i   (req_va_i[OFF_W-1:0]),
    .len_i   (len_q),
    .ent_i   (ent),
    .cause_o (cause),
    .pa_o    (pa)
  );

  pt_rsp #(.VPN_W(VPN_W), .PA_W(PA_W)) u_rsp (
    .clk_i, .rst_ni,
    .en_i    (req_valid_i),
    .fault_i (cause != CAUSE_NONE),
    .pa_i    (pa),
    .vpn_i   (vpn),
    .valid_o (rsp_valid_o),
    .fault_o (rsp_fault_o),
    .pa_o    (rsp_pa_o),
    .vpn_o   (rsp_vpn_o)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned OFF_W = 10,
  localparam int unsigned VPN_W = VA_W - OFF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_va_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic             rsp_fault_o,
  input logic [VPN_W-1:0] rsp_vpn_o,
  input logic [VPN_W:0]   len_q
);
  // R7
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R7
  rsp_vpn_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_vpn_o == $past(req_va_i[VA_W-1:OFF_W]));
  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i ##1 !rsp_fault_o) |-> rsp_pa_o[OFF_W-1:0] == $past(req_va_i[OFF_W-1:0]));
  // R4
  bound_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && {1'b0, req_va_i[VA_W-1:OFF_W]} >= len_q) |=> rsp_fault_o);
  // R3
  fault_pa_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> rsp_pa_o == '0);
endmodule

bind page_xlate_top page_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_va_i, .rsp_valid_o,
  .rsp_pa_o, .rsp_fault_o, .rsp_vpn_o, .len_q
);

// File: tb/sim_page_xlate_top.sv
module sim_page_xlate_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [15:0] req_va_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [15:0] rsp_pa_o;
  logic [5:0]  rsp_vpn_o;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_idx_i = '0;
  logic [8:0]  cfg_wdata_i = '0;
  logic [8:0]  cfg_rdata_o;
  logic        len_we_i = 1'b0;
  logic [6:0]  len_i = '0;

  int n_chk = 0, n_bad = 0;
  int m_v[64], m_r[64], m_d[64], m_f[64];
  int m_len;
  int e_valid, e_fault, e_pa, e_vpn;

  always #5 clk_i = ~clk_i;

  page_xlate_top u0 (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ent_val(int i);
    return (m_v[i] << 8) | (m_r[i] << 7) | (m_d[i] << 6) | m_f[i];
  endfunction

  // inputs are already driven; advance one edge, compare, update model
  task automatic step();
    int vpn, off, flt;
    vpn = int'(req_va_i[15:10]);
    off = int'(req_va_i[9:0]);
    flt = (vpn >= m_len || m_v[vpn] == 0) ? 1 : 0;
    e_valid = int'(req_valid_i);
    if (req_valid_i) begin
      e_fault = flt;
      e_pa    = flt ? 0 : (m_f[vpn] << 10) | off;
      e_vpn   = vpn;
      if (!flt) begin
        m_r[vpn] = 1;
        if (req_write_i) m_d[vpn] = 1;
      end
    end
    if (cfg_we_i) begin
      int i = int'(cfg_idx_i);
      m_f[i] = int'(cfg_wdata_i[5:0]);
      m_d[i] = int'(cfg_wdata_i[6]);
      m_r[i] = int'(cfg_wdata_i[7]);
      m_v[i] = int'(cfg_wdata_i[8]);
    end
    if (len_we_i) m_len = int'(len_i);
    @(posedge clk_i); #1;
    chk("R7 rsp_valid", int'(rsp_valid_o), e_valid);
    if (e_valid) begin
      chk("R3/R4 fault", int'(rsp_fault_o), e_fault);
      chk("R1/R2 pa", int'(rsp_pa_o), e_pa);
      chk("R7 vpn", int'(rsp_vpn_o), e_vpn);
    end
    chk("R5/R6/R9 readback", int'(cfg_rdata_o), ent_val(int'(cfg_idx_i)));
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; cfg_we_i = 1'b0; len_we_i = 1'b0;
  endtask

  task automatic wr_ent(int i, int v);
    cfg_we_i = 1'b1; cfg_idx_i = 6'(i); cfg_wdata_i = 9'(v); step();
  endtask
  task automatic xl(int va, bit w, int rd_idx);
    req_valid_i = 1'b1; req_va_i = 16'(va); req_write_i = w; cfg_idx_i = 6'(rd_idx); step();
  endtask
  task automatic set_len(int l);
    len_we_i = 1'b1; len_i = 7'(l); step();
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i]=0; m_r[i]=0; m_d[i]=0; m_f[i]=0; end
    m_len = 64;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 reset state
    chk("R8 rsp_valid", int'(rsp_valid_o), 0);
    for (int i = 0; i < 64; i += 21) begin
      cfg_idx_i = 6'(i); #1; chk("R8 entry", int'(cfg_rdata_o), 0);
    end
    xl(16'h0400, 0, 1);                 // R8: all invalid -> R3 fault
    // R9 load entries: valid bit 8
    wr_ent(1, 9'h100 | 7);
    wr_ent(5, 9'h100 | 0);
    wr_ent(3, 9'h100 | 9);
    wr_ent(63, 9'h100 | 6'h2A);
    xl(16'h041C, 0, 1);                 // R2 example -> 0x1C1C
    chk("R2 example", int'(rsp_pa_o), 16'h1C1C);
    chk("R5 ref set, dirty clear", int'(cfg_rdata_o), 9'h187);
    xl(16'h08AD, 0, 2);                 // R3 invalid entry
    chk("R3 fault", int'(rsp_fault_o), 1);
    xl(16'h157B, 1, 5);                 // R5 write sets dirty
    chk("R2 pa", int'(rsp_pa_o), 16'h017B);
    chk("R5 dirty", int'(cfg_rdata_o), 9'h1C0);
    set_len(4);
    xl(16'h157B, 1, 5);                 // R4 vpn 5 >= 4
    wr_ent(3, 9'h100 | 9);
    xl(16'h0FFF, 0, 3);                 // R4 vpn 3 == len-1 legal
    chk("R4 edge ok", int'(rsp_fault_o), 0);
    set_len(0);
    xl(16'h041C, 1, 1);                 // R4 len 0 faults, R6 no change
    set_len(64);
    xl(16'hFFFF, 1, 63);                // R4 top page with len 64
    chk("R2 top page", int'(rsp_pa_o), 16'hABFF);
    // R10 same-cycle software write wins, translation uses old frame
    req_valid_i = 1'b1; req_va_i = 16'h0401; req_write_i = 1'b1;
    cfg_we_i = 1'b1; cfg_idx_i = 6'd1; cfg_wdata_i = 9'h112; step();
    chk("R10 old frame", int'(rsp_pa_o), 16'h1C01);
    chk("R10 cfg wins", int'(cfg_rdata_o), 9'h112);
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      req_valid_i = 1'($urandom_range(0, 3) != 0);
      req_va_i    = 16'($urandom);
      req_write_i = 1'($urandom);
      cfg_we_i    = 1'($urandom_range(0, 5) == 0);
      cfg_idx_i   = cfg_we_i && $urandom_range(0,1) ? req_va_i[15:10] : 6'($urandom);
      cfg_wdata_i = 9'($urandom);
      len_we_i    = 1'($urandom_range(0, 40) == 0);
      len_i       = 7'($urandom_range(0, 70));
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule